// File: doc/BRIEF.md
# IDE PIO Strobe Timing Generator

This block produces the read and write strobes for one IDE channel that serves two drives. Each accepted transfer passes through three phases: address setup, an active phase in which one strobe is driven low, and recovery. The length of each phase is a programmable number of clocks. The setup length comes from a per-drive field. The active and recovery lengths come from per-drive timing bytes, one for reads and one for writes. Byte-wide (8-bit) transfers use a single shared timing byte instead.

A host-side controller presents a request that carries the drive, the direction and the width. The block accepts the request only when it is idle and globally enabled. It latches the timing that applies at that moment, and it reports a one-clock completion pulse at the end of recovery. A slow device can hold the ready input low to stretch the active phase.

Top module: `pio_strobe_gen`

## Requirements
- R1: While reset is high and in the first cycle after it, `dior_n` and `diow_n` are high and `busy` and `done` are low.
- R2: A request is accepted at a rising edge where `req_valid`=1, `enable`=1 and `busy`=0. The setup phase then lasts S clocks. S is the 2-bit setup field of the addressed drive (`req_drive`=0 selects drive 0, 1 selects drive 1). No strobe is driven during setup.
- R3: For a 16-bit read (`req_write`=0, `req_byte`=0), `dior_n` is low for A clocks right after setup, then recovery lasts R clocks. A is bits 7:4 and R is bits 3:0 of the addressed drive's read timing byte.
- R4: For a 16-bit write (`req_write`=1, `req_byte`=0), `diow_n` is low for A clocks and recovery lasts R clocks. A and R are taken from bits 7:4 and 3:0 of the addressed drive's write timing byte.
- R5: For a byte transfer (`req_byte`=1), A and R are taken from bits 7:4 and 3:0 of `byte_tim`, whatever the drive and direction. Setup still uses the addressed drive's field.
- R6: A programmed setup, active or recovery count of 0 gives a phase of 1 clock.
- R7: While `iordy` is low, the active phase does not end. Once the programmed active count has run out, the strobe stays low until a rising edge samples `iordy` high. Recovery starts after that edge.
- R8: While `enable` is 0, no request is accepted. `busy` stays low and both strobes stay high.
- R9: `busy` is high from the accepting edge until recovery ends. `done` is high for exactly one clock, which is the first idle clock after recovery. Requests presented while `busy` is high are dropped and do not start a later transfer.
- R10: The setup, active and recovery lengths are fixed at the accepting edge. Changes to the timing inputs during a transfer do not change it.
- R11: `dior_n` and `diow_n` are never low together, and a strobe is low only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Global enable; 0 blocks new transfers |
| req_valid | input | 1 | Transfer request |
| req_drive | input | 1 | Drive addressed by the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = 8-bit byte cycle |
| drv0_setup | input | 2 | Drive 0 setup clocks |
| drv0_rd_tim | input | 8 | Drive 0 read timing {active, recovery} |
| drv0_wr_tim | input | 8 | Drive 0 write timing {active, recovery} |
| drv1_setup | input | 2 | Drive 1 setup clocks |
| drv1_rd_tim | input | 8 | Drive 1 read timing {active, recovery} |
| drv1_wr_tim | input | 8 | Drive 1 write timing {active, recovery} |
| byte_tim | input | 8 | Shared byte-cycle timing {active, recovery} |
| iordy | input | 1 | Device ready; low stretches the active phase |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock completion pulse |

## Verification
Cycle 0 is the clock period that follows the accepting edge. With effective lengths S, A and R (a programmed 0 counts as 1), the strobe is low in cycles S through S+A-1, `busy` is high in cycles 0 through S+A+R-1, and `done` is high in cycle S+A+R alone. When `iordy` is held low and raised during cycle k, the strobe instead stays low through cycle max(S+A-1, k), and the later phases shift by the same amount. The bench computes these cycle indices from the programmed values. It samples every output on each falling edge from cycle 0 through the done cycle, so any phase that is one clock early or late is caught.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int CNT_W = 4;
    localparam int SET_W = 2;
    localparam int TIM_W = 2 * CNT_W;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        cnt_t setup;
        cnt_t active;
        cnt_t recov;
    } phase_len_t;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_RECOV  = 2'd3
    } phase_t;

    // Counter load value so that a phase lasts max(n,1) clocks.
    function automatic cnt_t load_val(cnt_t n);
        return (n == '0) ? '0 : n - cnt_t'(1);
    endfunction

endpackage

// File: rtl/pio_timing_sel.sv
module pio_timing_sel
    import pio_pkg::*;
#(
    parameter int NDRV  = 2,
    parameter int DRV_W = (NDRV > 1) ? $clog2(NDRV) : 1
) (
    input  logic [DRV_W-1:0]            drive,
    input  logic                        write,
    input  logic                        byte_mode,
    input  logic [NDRV-1:0][SET_W-1:0]  setup_fld,
    input  logic [NDRV-1:0][TIM_W-1:0]  rd_tim,
    input  logic [NDRV-1:0][TIM_W-1:0]  wr_tim,
    input  logic [TIM_W-1:0]            byte_tim,
    output phase_len_t                  len
);

    logic [TIM_W-1:0] tim_pick;

    always_comb begin
        if (byte_mode)
            tim_pick = byte_tim;
        else if (write)
            tim_pick = wr_tim[drive];
        else
            tim_pick = rd_tim[drive];
    end

    always_comb begin
        len.setup  = cnt_t'(setup_fld[drive]);
        len.active = tim_pick[TIM_W-1:CNT_W];
        len.recov  = tim_pick[CNT_W-1:0];
    end

endmodule

// File: rtl/pio_phase_seq.sv
module pio_phase_seq
    import pio_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       start_write,
    input  phase_len_t len_in,
    input  logic       iordy,
    output phase_t     phase,
    output logic       is_write,
    output logic       done
);

    phase_len_t len_q;
    cnt_t       cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            len_q    <= '0;
            is_write <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase    <= PH_SETUP;
                        len_q    <= len_in;
                        is_write <= start_write;
                        cnt      <= load_val(len_in.setup);
                    end
                end
                PH_SETUP: begin
                    if (cnt == '0) begin
                        phase <= PH_ACTIVE;
                        cnt   <= load_val(len_q.active);
                    end else begin
                        cnt <= cnt - cnt_t'(1);
                    end
                end
                PH_ACTIVE: begin
                    if (cnt != '0) begin
                        cnt <= cnt - cnt_t'(1);
                    end else if (iordy) begin
                        phase <= PH_RECOV;
                        cnt   <= load_val(len_q.recov);
                    end
                end
                PH_RECOV: begin
                    if (cnt == '0) begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                    end else begin
                        cnt <= cnt - cnt_t'(1);
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pio_strobe_gen.sv
module pio_strobe_gen
    import pio_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       req_valid,
    input  logic       req_drive,
    input  logic       req_write,
    input  logic       req_byte,
    input  logic [1:0] drv0_setup,
    input  logic [7:0] drv0_rd_tim,
    input  logic [7:0] drv0_wr_tim,
    input  logic [1:0] drv1_setup,
    input  logic [7:0] drv1_rd_tim,
    input  logic [7:0] drv1_wr_tim,
    input  logic [7:0] byte_tim,
    input  logic       iordy,
    output logic       dior_n,
    output logic       diow_n,
    output logic       busy,
    output logic       done
);

    localparam int NDRV = 2;

    logic [NDRV-1:0][SET_W-1:0] setup_fld;
    logic [NDRV-1:0][TIM_W-1:0] rd_tim;
    logic [NDRV-1:0][TIM_W-1:0] wr_tim;
    phase_len_t                 sel_len;
    phase_t                     phase;
    logic                       cur_write;
    logic                       start;

    assign setup_fld = {drv1_setup, drv0_setup};
    assign rd_tim    = {drv1_rd_tim, drv0_rd_tim};
    assign wr_tim    = {drv1_wr_tim, drv0_wr_tim};

    pio_timing_sel #(.NDRV(NDRV)) u_sel (
        .drive     (req_drive),
        .write     (req_write),
        .byte_mode (req_byte),
        .setup_fld (setup_fld),
        .rd_tim    (rd_tim),
        .wr_tim    (wr_tim),
        .byte_tim  (byte_tim),
        .len       (sel_len)
    );

    assign start = req_valid && enable && (phase == PH_IDLE);

    pio_phase_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .start_write (req_write),
        .len_in      (sel_len),
        .iordy       (iordy),
        .phase       (phase),
        .is_write    (cur_write),
        .done        (done)
    );

    assign busy   = (phase != PH_IDLE);
    assign dior_n = !((phase == PH_ACTIVE) && !cur_write);
    assign diow_n = !((phase == PH_ACTIVE) && cur_write);

endmodule

// File: rtl/pio_strobe_gen_chk.sv
module pio_strobe_gen_chk (
    input logic clk,
    input logic rst,
    input logic enable,
    input logic iordy,
    input logic dior_n,
    input logic diow_n,
    input logic busy,
    input logic done
);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (dior_n && diow_n && !busy && !done));

    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!dior_n && !diow_n));

    // R11
    strobe_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (!dior_n || !diow_n) |-> busy);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    done_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R8
    no_start_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !enable) |=> !busy);

    // R7
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!dior_n && !iordy) |=> !dior_n);

    // R7
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!diow_n && !iordy) |=> !diow_n);

endmodule

bind pio_strobe_gen pio_strobe_gen_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .enable (enable),
    .iordy  (iordy),
    .dior_n (dior_n),
    .diow_n (diow_n),
    .busy   (busy),
    .done   (done)
);

// File: tb/pio_strobe_gen_tb.sv
module pio_strobe_gen_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_drive = 1'b0;
    logic       req_write = 1'b0;
    logic       req_byte = 1'b0;
    logic [1:0] drv0_setup, drv1_setup;
    logic [7:0] drv0_rd_tim, drv0_wr_tim, drv1_rd_tim, drv1_wr_tim, byte_tim;
    logic       iordy = 1'b1;
    logic       dior_n, diow_n, busy, done;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pio_strobe_gen u_dut (
        .clk(clk), .rst(rst), .enable(enable), .req_valid(req_valid),
        .req_drive(req_drive), .req_write(req_write), .req_byte(req_byte),
        .drv0_setup(drv0_setup), .drv0_rd_tim(drv0_rd_tim), .drv0_wr_tim(drv0_wr_tim),
        .drv1_setup(drv1_setup), .drv1_rd_tim(drv1_rd_tim), .drv1_wr_tim(drv1_wr_tim),
        .byte_tim(byte_tim), .iordy(iordy),
        .dior_n(dior_n), .diow_n(diow_n), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic set_defaults();
        drv0_setup  = 2'd2; drv0_rd_tim = 8'h32; drv0_wr_tim = 8'h41;
        drv1_setup  = 2'd1; drv1_rd_tim = 8'h23; drv1_wr_tim = 8'h15;
        byte_tim    = 8'h54;
    endtask

    // rel < 0: iordy stays high; otherwise iordy low until raised in cycle rel
    task automatic run_xfer(input bit drv, input bit wr, input bit bm,
                            input int s, input int a, input int r,
                            input int rel, input bit chg, input bit intr,
                            input string tag);
        int se, ae, re, aend, tot;
        se = (s == 0) ? 1 : s;
        ae = (a == 0) ? 1 : a;
        re = (r == 0) ? 1 : r;
        aend = se + ae - 1;
        if (rel > aend) aend = rel;
        tot = aend + re + 1;
        @(negedge clk);
        req_drive = drv; req_write = wr; req_byte = bm; req_valid = 1'b1;
        if (rel >= 0) iordy = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        if (chg) begin
            drv0_setup = 2'd3; drv1_setup = 2'd3;
            drv0_rd_tim = 8'hFF; drv0_wr_tim = 8'hFF;
            drv1_rd_tim = 8'hFF; drv1_wr_tim = 8'hFF; byte_tim = 8'hFF;
        end
        for (int k = 0; k <= tot; k++) begin
            bit act_ph;
            act_ph = (k >= se) && (k <= aend);
            check(dior_n == !(act_ph && !wr), tag, dior_n, !(act_ph && !wr));
            check(diow_n == !(act_ph && wr), tag, diow_n, !(act_ph && wr));
            check(busy == (k < tot), {tag, " R9 busy"}, busy, k < tot);
            check(done == (k == tot), {tag, " R9 done"}, done, k == tot);
            check(!((dior_n == 1'b0) && (diow_n == 1'b0)), "R11 both strobes", 0, 1);
            if (k == rel) iordy = 1'b1;
            if (intr && k == 1) begin
                req_drive = !drv; req_write = !wr; req_valid = 1'b1;
            end
            if (intr && k == 2) req_valid = 1'b0;
            @(negedge clk);
        end
        if (intr) begin
            for (int k = 0; k < 3; k++) begin
                check(busy == 1'b0, "R9 dropped request", busy, 0);
                @(negedge clk);
            end
        end
        iordy = 1'b1;
        if (chg) set_defaults();
    endtask

    task automatic t_reset();
        check(dior_n && diow_n, "R1 strobes in reset", {dior_n, diow_n}, 3);
        check(!busy && !done, "R1 busy/done in reset", {busy, done}, 0);
        @(negedge clk);
        rst = 1'b0;
        check(dior_n && diow_n && !busy && !done, "R1 after reset", {dior_n, diow_n, busy, done}, 12);
    endtask

    task automatic t_read16();
        run_xfer(0, 0, 0, 2, 3, 2, -1, 0, 0, "R2 R3 drive0 read");
        run_xfer(1, 0, 0, 1, 2, 3, -1, 0, 0, "R2 R3 drive1 read");
    endtask

    task automatic t_write16();
        run_xfer(1, 1, 0, 1, 1, 5, -1, 0, 0, "R4 drive1 write");
        run_xfer(0, 1, 0, 2, 4, 1, -1, 0, 0, "R4 drive0 write");
    endtask

    task automatic t_byte();
        run_xfer(1, 0, 1, 1, 5, 4, -1, 0, 0, "R5 byte read drive1");
        run_xfer(0, 1, 1, 2, 5, 4, -1, 0, 0, "R5 byte write drive0");
    endtask

    task automatic t_zero();
        drv0_setup = 2'd0; drv0_rd_tim = 8'h00;
        run_xfer(0, 0, 0, 0, 0, 0, -1, 0, 0, "R6 zero counts");
        set_defaults();
    endtask

    task automatic t_iordy();
        run_xfer(0, 0, 0, 2, 3, 2, 8, 0, 0, "R7 iordy stretch read");
        run_xfer(1, 1, 0, 1, 1, 5, 0, 0, 0, "R7 iordy short write");
    endtask

    task automatic t_disabled();
        @(negedge clk);
        enable = 1'b0; req_valid = 1'b1; req_drive = 1'b0; req_write = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check(!busy && dior_n && diow_n, "R8 disabled no start", {busy, dior_n, diow_n}, 3);
        end
        req_valid = 1'b0;
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        check(!busy, "R8 no late start", busy, 0);
    endtask

    task automatic t_sampled();
        run_xfer(1, 0, 0, 1, 2, 3, -1, 1, 0, "R10 timing latched");
    endtask

    task automatic t_busy_req();
        run_xfer(0, 1, 0, 2, 4, 1, -1, 0, 1, "R9 request while busy");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        set_defaults();
        repeat (3) @(negedge clk);
        t_reset();
        t_read16();
        t_write16();
        t_byte();
        t_zero();
        t_iordy();
        t_disabled();
        t_sampled();
        t_busy_req();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule